// File: doc/BRIEF.md
# Latched Event Interrupt Flag Controller

This block gathers seven single-cycle event pulses into sticky status flags and drives one interrupt line from them. Four of the events come from capture logic, one from a counter wrap, one from a period match and one from a compare match. A mode input marks the timer as either a capture timer or a waveform generator. Each event only records when it is meaningful in the current mode, except the wrap event, which records in both modes.

Software writes through three strobed registers. The first is an enable mask. The second clears flags when a 1 is written to a bit. The third sets flags when a 1 is written to a bit. A global interrupt flag latches once when an enabled event flag is pending. It then stays set, so no new interrupt is generated, until software clears it. If enabled events are still pending after that clear, the global flag is raised again.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset `flag_o` and `irq_o` are 0. The flag readback layout is: bit 0 global, bits 1-4 capture events 1-4 (`evt_i[0..3]`), bit 5 wrap (`evt_i[4]`), bit 6 period match (`evt_i[5]`), bit 7 compare match (`evt_i[6]`). Bits 15-8 always read 0.
- R2: A capture event pulse sets its flag one cycle later only while `mode_i` is 0 (capture mode). While `mode_i` is 1 it leaves the flag unchanged.
- R3: A period-match or compare-match pulse sets its flag one cycle later only while `mode_i` is 1 (waveform mode). While `mode_i` is 0 it leaves the flag unchanged.
- R4: A wrap pulse sets flag bit 5 one cycle later in either mode.
- R5: Event flags stay set until a clear write (`clr_we_i`) carries a 1 at their bit. A 0 bit in a clear write leaves the flag unchanged.
- R6: A force write (`frc_we_i`) sets every event flag whose data bit is 1, whatever the mode. Force data bit 0 is ignored.
- R7: When an event pulse (or a force) and a clear write hit the same flag in the same cycle, the flag ends up set.
- R8: The enable register (`en_we_i`, data bits 7-1) selects which event flags can raise the global flag. The global flag sets one cycle after an enabled event flag reads 1 while the global flag is 0. Flags that are not enabled never raise it.
- R9: Once set, the global flag stays 1 whatever further events arrive. It is cleared only by a clear write with data bit 0 set.
- R10: When the global flag is cleared while an enabled event flag is still set, it reads 0 for exactly one cycle and then sets again.
- R11: `irq_o` always equals flag bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Event pulses: capture 1-4, wrap, period match, compare match |
| mode_i | input | 1 | 0 capture mode, 1 waveform mode |
| en_we_i | input | 1 | Enable register write strobe |
| clr_we_i | input | 1 | Clear register write strobe (write-one-to-clear) |
| frc_we_i | input | 1 | Force register write strobe (write-one-to-set) |
| wr_data_i | input | 16 | Write data for the three registers |
| flag_o | output | 16 | Flag register readback |
| irq_o | output | 1 | Interrupt line, equal to the global flag |

## Verification
Event flags and write effects appear one clock edge after the cycle in which the stimulus is presented. The global flag, and with it `irq_o`, follows one further edge later, because it looks at the registered event flags. The bench drives every stimulus on the falling edge and holds it for one rising edge. It samples `flag_o` and `irq_o` at the next falling edge to check the flags, and one falling edge after that to check the global flag. The re-raise after a global clear is checked at both edges, so that the single low cycle is seen.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_CAP = 4;
  localparam int NUM_EVT = NUM_CAP + 3;

  typedef enum logic {
    MODE_CAPTURE = 1'b0,
    MODE_WAVE    = 1'b1
  } evt_mode_e;
endpackage

// File: rtl/evt_gate.sv
module evt_gate #(
  parameter int NUM_CAP = evt_flag_pkg::NUM_CAP,
  localparam int NUM_EVT = NUM_CAP + 3
) (
  input  logic               mode_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [NUM_EVT-1:0] evt_o
);
  import evt_flag_pkg::*;

  logic cap_act, wave_act;
  assign cap_act  = (evt_mode_e'(mode_i) == MODE_CAPTURE);
  assign wave_act = (evt_mode_e'(mode_i) == MODE_WAVE);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_gate
    if (i < NUM_CAP) begin : g_cap
      assign evt_o[i] = evt_i[i] & cap_act;
    end else if (i == NUM_CAP) begin : g_wrap
      assign evt_o[i] = evt_i[i];
    end else begin : g_wave
      assign evt_o[i] = evt_i[i] & wave_act;
    end
  end
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int NUM_EVT = evt_flag_pkg::NUM_EVT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] frc_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] flag_o
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic q;
    // set and force take priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[i] | frc_i[i] | (q & ~clr_i[i]);
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int NUM_EVT = evt_flag_pkg::NUM_EVT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] flag_i,
  input  logic [NUM_EVT-1:0] en_i,
  input  logic               clr_i,
  output logic               glb_o
);
  logic glb_q, pend;

  assign pend = |(flag_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            glb_q <= 1'b0;
    else if (clr_i)         glb_q <= 1'b0;
    else if (!glb_q && pend) glb_q <= 1'b1;
  end

  assign glb_o = glb_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int REG_W   = evt_flag_pkg::REG_W,
  parameter int NUM_CAP = evt_flag_pkg::NUM_CAP,
  localparam int NUM_EVT = NUM_CAP + 3,
  localparam int PAD_W   = REG_W - NUM_EVT - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               mode_i,
  input  logic               en_we_i,
  input  logic               clr_we_i,
  input  logic               frc_we_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   flag_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] evt_act, ev_clr, ev_frc, ev_flag, en_q;
  logic               glb_clr, glb;
  logic [PAD_W-1:0]   unused_hi;

  assign unused_hi = wr_data_i[REG_W-1:NUM_EVT+1];

  assign ev_clr  = clr_we_i ? wr_data_i[NUM_EVT:1] : '0;
  assign ev_frc  = frc_we_i ? wr_data_i[NUM_EVT:1] : '0;
  assign glb_clr = clr_we_i & wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= wr_data_i[NUM_EVT:1];
  end

  evt_gate #(.NUM_CAP(NUM_CAP)) u_gate (
    .mode_i (mode_i),
    .evt_i  (evt_i),
    .evt_o  (evt_act)
  );

  evt_flag_bank #(.NUM_EVT(NUM_EVT)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_act),
    .frc_i  (ev_frc),
    .clr_i  (ev_clr),
    .flag_o (ev_flag)
  );

  irq_latch #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (ev_flag),
    .en_i   (en_q),
    .clr_i  (glb_clr),
    .glb_o  (glb)
  );

  assign flag_o = {{PAD_W{1'b0}}, ev_flag, glb};
  assign irq_o  = glb;
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int REG_W   = 16,
  parameter int NUM_CAP = 4,
  localparam int NUM_EVT = NUM_CAP + 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               mode_i,
  input logic               clr_we_i,
  input logic               frc_we_i,
  input logic [REG_W-1:0]   wr_data_i,
  input logic [REG_W-1:0]   flag_o,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] en_q_i
);
  assert_cap_in_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && evt_i[0]) |=> flag_o[1]);

  assert_cap_blocked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && evt_i[0] && !flag_o[1] && !(frc_we_i && wr_data_i[1])) |=> !flag_o[1]);

  assert_prd_in_wave_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && evt_i[NUM_CAP+1]) |=> flag_o[NUM_CAP+2]);

  assert_cmp_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && evt_i[NUM_CAP+2] && !flag_o[NUM_CAP+3] && !(frc_we_i && wr_data_i[NUM_CAP+3]))
      |=> !flag_o[NUM_CAP+3]);

  assert_wrap_any_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[NUM_CAP] |=> flag_o[NUM_CAP+1]);

  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[1] && !(clr_we_i && wr_data_i[1])) |=> flag_o[1]);

  assert_set_beats_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[NUM_CAP] && clr_we_i && wr_data_i[NUM_CAP+1]) |=> flag_o[NUM_CAP+1]);

  assert_glb_raise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && |(flag_o[NUM_EVT:1] & en_q_i) && !(clr_we_i && wr_data_i[0])) |=> irq_o);

  assert_glb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(clr_we_i && wr_data_i[0])) |=> irq_o);

  assert_glb_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && wr_data_i[0]) |=> !irq_o);

  assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o[REG_W-1:NUM_EVT+1] == '0);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.REG_W(REG_W), .NUM_CAP(NUM_CAP)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .mode_i    (mode_i),
  .clr_we_i  (clr_we_i),
  .frc_we_i  (frc_we_i),
  .wr_data_i (wr_data_i),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .en_q_i    (en_q)
);

// File: tb/sim_evt_irq_ctrl.sv
module sim_evt_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        mode = 1'b0;
  logic        en_we = 1'b0, clr_we = 1'b0, frc_we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] flag;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  evt_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .mode_i(mode),
    .en_we_i(en_we), .clr_we_i(clr_we), .frc_we_i(frc_we),
    .wr_data_i(wdata), .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // present stimulus for one rising edge; returns on the next falling edge
  task automatic drive(input logic [6:0] e, input logic we_en, input logic we_clr,
                       input logic we_frc, input logic [15:0] d);
    evt = e; en_we = we_en; clr_we = we_clr; frc_we = we_frc; wdata = d;
    @(negedge clk);
    evt = '0; en_we = 0; clr_we = 0; frc_we = 0; wdata = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic clear_all();
    drive('0, 0, 1, 0, 16'hFFFF);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 reset flags", flag, 16'h0000);
    chk("R11 reset irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_capture_mode();
    mode = 1'b0;
    drive(7'h7F, 0, 0, 0, '0);
    chk("R2/R3/R4 capture mode all events", flag, 16'h003E);
    idle();
    chk("R8 disabled flags no irq", {15'd0, irq}, 16'h0000);
    clear_all();
    chk("R5 clear all", flag, 16'h0000);
  endtask

  task automatic t_wave_mode();
    mode = 1'b1;
    drive(7'h7F, 0, 0, 0, '0);
    chk("R3/R2/R4 wave mode all events", flag, 16'h00E0);
    clear_all();
    mode = 1'b0;
  endtask

  task automatic t_sticky_clear();
    drive('0, 0, 0, 1, 16'hFFFF);
    chk("R6 force all, bit0 ignored", flag, 16'h00FE);
    chk("R1 reserved read zero", flag & 16'hFF00, 16'h0000);
    idle();
    chk("R6 force no global when disabled", flag, 16'h00FE);
    drive('0, 0, 1, 0, 16'h0006);
    chk("R5 clear selected bits", flag, 16'h00F8);
    drive('0, 0, 1, 0, 16'h0000);
    chk("R5 zero clear no effect", flag, 16'h00F8);
    idle(); idle();
    chk("R5 flags sticky", flag, 16'h00F8);
    clear_all();
  endtask

  task automatic t_force_gated();
    mode = 1'b0;
    drive('0, 0, 0, 1, 16'h00C0);
    chk("R6 force wave flags in capture mode", flag, 16'h00C0);
    clear_all();
  endtask

  task automatic t_set_wins();
    mode = 1'b0;
    drive('0, 0, 0, 1, 16'h0002);
    chk("R6 force cap1", flag, 16'h0002);
    drive(7'h01, 0, 1, 0, 16'h0002);
    chk("R7 event beats clear", flag, 16'h0002);
    drive(7'h10, 0, 1, 0, 16'h0020);
    chk("R7 wrap event beats clear", flag, 16'h0022);
    clear_all();
    chk("R7 clear alone", flag, 16'h0000);
  endtask

  task automatic t_global();
    mode = 1'b0;
    drive('0, 1, 0, 0, 16'h0020);
    drive(7'h10, 0, 0, 0, '0);
    chk("R8 wrap flag before global", flag, 16'h0020);
    chk("R8 irq not yet", {15'd0, irq}, 16'h0000);
    idle();
    chk("R8 global set", flag, 16'h0021);
    chk("R11 irq follows global", {15'd0, irq}, 16'h0001);
    drive(7'h01, 0, 0, 0, '0);
    chk("R9 global held with new event", flag, 16'h0023);
    drive('0, 0, 1, 0, 16'h0001);
    chk("R10 global cleared one cycle", flag, 16'h0022);
    chk("R11 irq low", {15'd0, irq}, 16'h0000);
    idle();
    chk("R10 global re-raised", flag, 16'h0023);
    chk("R11 irq high again", {15'd0, irq}, 16'h0001);
    clear_all();
    chk("R9 full clear", flag, 16'h0000);
    drive('0, 0, 0, 1, 16'h0002);
    idle(); idle();
    chk("R8 disabled flag no global", flag, 16'h0002);
    clear_all();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_capture_mode();
    t_wave_mode();
    t_sticky_clear();
    t_force_gated();
    t_set_wins();
    t_global();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule